// File: doc/BRIEF.md
# Latched Multiplexer Channel-Select Controller

This block is the digital control path of a processor-programmable analog multiplexer. A host writes a channel address and an on/off flag through a write strobe, which is active low. While the strobe is low, the capture stage passes its inputs straight through. When the strobe rises, the stage keeps the last values it saw. The captured word is decoded into switch-drive lines. Only one analog channel can ever be closed. Whenever the selection changes, every switch opens for a guard interval before the new one closes.

A build-time parameter selects one of two modes. In the single-ended mode, a 3-bit address picks one of eight switches. In the differential mode, a 2-bit address picks one of four channel pairs, and the A and B switches of that pair close together. The strobe, the on/off flag and the address arrive asynchronously and pass through two-flop synchronizers. The master reset is active low. It opens all switches and clears the captured word at once, and its release is synchronised to the clock. All pins are plain control levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `chsel_top`

## Requirements
- R1: In single-ended mode (DIFF=0), once the captured flag is 1, the captured address k (0 to 7) drives `sw_on` to exactly bit k (address 000 selects the first channel, 111 the eighth), and no other bit.
- R2: In differential mode (DIFF=1), the captured address k (0 to 3) drives bit k (A side) and bit k+4 (B side) of `sw_on` together. In every cycle, the B half `sw_on[7:4]` equals the A half `sw_on[3:0]`.
- R3: While `wr_n` is low, the capture stage is transparent. An input change made between clock edges shows up at `sw_on` on the 5+GAP-th rising edge after the change. The old selection stays until the 3rd edge, and all switches are off from the 4th edge through the (4+GAP)-th edge.
- R4: While `wr_n` is high, changes on `addr` and `en` have no effect. `sw_on` keeps the selection that was captured before the strobe rose.
- R5: While `rst_n` is low, `sw_on` is all zero at once, without waiting for a clock edge, whatever `wr_n`, `en` and `addr` do.
- R6: After reset is released, `sw_on` stays all zero until a write (with `wr_n` low) captures a flag of 1.
- R7: A captured flag of 0 turns every switch off, whatever address is captured.
- R8: On any change of selection, the output is all zero for at least GAP sampled cycles between two different non-zero values. Two different non-zero values never appear in consecutive cycles.
- R9: If the selection changes again during the guard interval, the interval restarts. The superseded selection never reaches `sw_on`; only the most recent one does.
- R10: In every cycle, at most one channel is driven. In single-ended mode `sw_on` is one-hot or zero; in differential mode its A half is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchronizers, the capture stage and the guard timer |
| rst_n | input | 1 | Master reset, active low; takes effect at once and is released in step with the clock |
| wr_n | input | 1 | Write strobe, active low; the capture stage is transparent while it is low |
| en | input | 1 | On/off flag, captured together with the address |
| addr | input | AW (3, or 2 when DIFF=1) | Channel address |
| sw_on | output | NSW (8) | Switch-drive lines; in differential mode, bits [3:0] are the A side and bits [7:4] the B side |

## Verification
The hardest situation to reach from the ports is a second selection change that lands inside a guard interval that is already running. It proves that the interval restarts and that the superseded channel never closes. The stimulus changes the address, then changes it again exactly two clock cycles later, while the strobe stays low. This places the second change in the capture stage while the guard counter is still non-zero. A monitor collects every value `sw_on` takes, which shows that the intermediate channel never appears. Both modes are swept over the full address and flag space, with the expected vectors computed arithmetically.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  // Number of selectable channels for a given switch count and mode.
  function automatic int chan_count(input bit diff, input int nsw);
    return diff ? nsw / 2 : nsw;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/chsel_rstsync.sv
module chsel_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [1:0] stage;

  // Asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign rst_q_n = stage[1];
endmodule

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      held <= RST_VAL;
    end else begin
      meta <= d;
      held <= meta;
    end
  end

  assign q = held;
endmodule

// File: rtl/chsel_latch.sv
module chsel_latch #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n_s,
  input  logic          en_s,
  input  logic [AW-1:0] addr_s,
  output logic          lat_en,
  output logic [AW-1:0] lat_addr
);
  // Sampled equivalent of a level-sensitive latch: it follows the inputs
  // while the strobe is low and keeps the last captured word otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_en   <= 1'b0;
      lat_addr <= '0;
    end else if (!wr_n_s) begin
      lat_en   <= en_s;
      lat_addr <= addr_s;
    end
  end

  // R4
  hold_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n_s |=> $stable({lat_en, lat_addr}));
endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
  parameter bit DIFF = 1'b0,
  parameter int NSW  = 8,
  parameter int NCH  = 8,
  parameter int AW   = 3
) (
  input  logic          lat_en,
  input  logic [AW-1:0] lat_addr,
  output logic [NSW-1:0] tgt
);
  logic [NCH-1:0] chan_sel;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign chan_sel[ch] = lat_en && (lat_addr == AW'(ch));
  end

  if (DIFF) begin : g_diff
    // A side in the low half, B side in the high half.
    assign tgt = {chan_sel, chan_sel};
  end else begin : g_single
    assign tgt = chan_sel;
  end
endmodule

// File: rtl/chsel_bbm.sv
module chsel_bbm
  import chsel_pkg::*;
#(
  parameter int NSW = 8,
  parameter int GAP = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NSW-1:0] tgt,
  output logic [NSW-1:0] drv
);
  localparam int CW = cnt_width(GAP);

  logic [NSW-1:0] tgt_q;
  logic [CW-1:0]  gap_cnt;
  logic           chg;

  assign chg = (tgt != tgt_q);

  // Any change opens every switch and (re)starts the guard interval; the
  // most recent target is driven once the counter has run out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      gap_cnt <= '0;
      drv     <= '0;
    end else begin
      tgt_q <= tgt;
      if (chg) begin
        gap_cnt <= CW'(GAP);
        drv     <= '0;
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - CW'(1);
        drv     <= '0;
      end else begin
        drv <= tgt_q;
      end
    end
  end

  // R8
  no_direct_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv != '0) |=> (drv == '0 || $stable(drv)));

  // R8
  break_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (drv == '0));

  // R9
  gap_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt != '0) |=> (drv == '0));
endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
#(
  parameter bit DIFF = 1'b0,
  parameter int NSW  = 8,
  parameter int GAP  = 3,
  localparam int NCH = chan_count(DIFF, NSW),
  localparam int AW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_n,
  input  logic           en,
  input  logic [AW-1:0]  addr,
  output logic [NSW-1:0] sw_on
);
  localparam int SW_W = AW + 2;
  localparam logic [SW_W-1:0] SYNC_RST = {1'b1, {(AW + 1){1'b0}}};

  logic            rst_q_n;
  logic [SW_W-1:0] raw_in;
  logic [SW_W-1:0] sync_out;
  logic            wr_n_s;
  logic            en_s;
  logic [AW-1:0]   addr_s;
  logic            lat_en;
  logic [AW-1:0]   lat_addr;
  logic [NSW-1:0]  tgt;

  chsel_rstsync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign raw_in = {wr_n, en, addr};

  chsel_sync #(.W(SW_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign {wr_n_s, en_s, addr_s} = sync_out;

  chsel_latch #(.AW(AW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_n_s   (wr_n_s),
    .en_s     (en_s),
    .addr_s   (addr_s),
    .lat_en   (lat_en),
    .lat_addr (lat_addr)
  );

  chsel_decode #(.DIFF(DIFF), .NSW(NSW), .NCH(NCH), .AW(AW)) u_dec (
    .lat_en   (lat_en),
    .lat_addr (lat_addr),
    .tgt      (tgt)
  );

  chsel_bbm #(.NSW(NSW), .GAP(GAP)) u_bbm (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tgt   (tgt),
    .drv   (sw_on)
  );

  // R5
  reset_opens_all_chk: assert property (@(posedge clk)
    !rst_n |-> (sw_on == '0));

  // R10
  single_channel_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(sw_on[NCH-1:0]));

  if (DIFF) begin : g_pair_chk
    // R2
    pair_match_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      sw_on[NSW-1:NCH] == sw_on[NCH-1:0]);
  end
endmodule

// File: tb/sim_chsel_top.sv
module sim_chsel_top;
  localparam int GAP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] sw_se;
  logic [7:0] sw_df;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [7:0] seen = '0;

  always #4 clk = ~clk;

  chsel_top #(.DIFF(1'b0), .NSW(8), .GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en), .addr(addr), .sw_on(sw_se));

  chsel_top #(.DIFF(1'b1), .NSW(8), .GAP(GAP)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en), .addr(addr[1:0]), .sw_on(sw_df));

  function automatic logic [7:0] ref_vec(input bit e, input int a, input bit diff);
    if (!e) return 8'h00;
    if (diff) return (8'h01 << (a % 4)) | (8'h01 << ((a % 4) + 4));
    return 8'h01 << a;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Per-cycle monitor: R10, R2 and the R8 guard interval.
  logic [7:0] last_se = '0, last_df = '0;
  int zrun_se = 0, zrun_df = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      last_se = '0; last_df = '0;
    end else if (mon_on) begin
      seen |= sw_se;
      chk("R10 single-ended one-hot", 8'($onehot0(sw_se)), 8'd1);
      chk("R10 differential one-hot", 8'($onehot0(sw_df[3:0])), 8'd1);
      chk("R2 pair match", {4'h0, sw_df[7:4]}, {4'h0, sw_df[3:0]});
      if (sw_se != 0) begin
        if (last_se != 0 && sw_se != last_se && zrun_se < GAP)
          chk("R8 guard single-ended", 8'(zrun_se), 8'(GAP));
        last_se = sw_se; zrun_se = 0;
      end else zrun_se++;
      if (sw_df != 0) begin
        if (last_df != 0 && sw_df != last_df && zrun_df < GAP)
          chk("R8 guard differential", 8'(zrun_df), 8'(GAP));
        last_df = sw_df; zrun_df = 0;
      end else zrun_df++;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    cyc(3);
    chk("R5 reset state se", sw_se, 8'h00);
    chk("R5 reset state df", sw_df, 8'h00);
    // Inputs are ignored during reset.
    wr_n = 1'b0; en = 1'b1; addr = 3'd5;
    cyc(10);
    chk("R5 reset ignores inputs se", sw_se, 8'h00);
    chk("R5 reset ignores inputs df", sw_df, 8'h00);
    wr_n = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    mon_on = 1'b1;
    cyc(15);
    chk("R6 off after release se", sw_se, 8'h00);
    chk("R6 off after release df", sw_df, 8'h00);

    // Sweep of flag and address, transparent mode (R1, R2, R7).
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 8; a++) begin
        wr_n = 1'b0; en = e[0]; addr = a[2:0];
        cyc(15);
        chk(e ? "R1 decode" : "R7 flag off", sw_se, ref_vec(e[0], a, 1'b0));
        chk(e ? "R2 decode" : "R7 flag off df", sw_df, ref_vec(e[0], a, 1'b1));
      end
    end

    // Exact latency of a transparent change (R3), from channel 7 to 2.
    addr = 3'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 old kept", sw_se, 8'h80);
    @(posedge clk); @(negedge clk);
    chk("R3 break starts", sw_se, 8'h00);
    repeat (GAP) @(posedge clk);
    @(negedge clk);
    chk("R3 break holds", sw_se, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R3 new driven", sw_se, 8'h04);

    // Hold with strobe high (R4).
    addr = 3'd4; en = 1'b1;
    cyc(15);
    wr_n = 1'b1;
    cyc(15);
    for (int e = 0; e < 2; e++) begin
      for (int a = 0; a < 8; a++) begin
        en = e[0]; addr = a[2:0];
        cyc(12);
        chk("R4 hold se", sw_se, 8'h10);
        chk("R4 hold df", sw_df, 8'h11);
      end
    end
    // Program-controlled off by writing flag 0 (R7).
    wr_n = 1'b0; en = 1'b0; addr = 3'd6;
    cyc(15);
    chk("R7 written off", sw_se, 8'h00);
    wr_n = 1'b1;
    cyc(15);
    chk("R7 stays off", sw_se, 8'h00);

    // Change inside a running guard interval (R9).
    wr_n = 1'b0; en = 1'b1; addr = 3'd1;
    cyc(15);
    seen = '0;
    addr = 3'd5;
    cyc(2);
    addr = 3'd6;
    cyc(20);
    chk("R9 superseded never driven", seen & 8'h20, 8'h00);
    chk("R9 latest driven", sw_se, 8'h40);

    // Asynchronous reset in mid-cycle (R5), then a write after release (R6).
    addr = 3'd3;
    cyc(15);
    #1 rst_n = 1'b0;
    #1;
    chk("R5 async clear se", sw_se, 8'h00);
    chk("R5 async clear df", sw_df, 8'h00);
    cyc(3);
    rst_n = 1'b1;
    cyc(20);
    chk("R6 write after release se", sw_se, 8'h08);
    chk("R6 write after release df", sw_df, 8'h88);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule